// File: doc/BRIEF.md
# Programmable Serial Flash Transaction Sequencer

This block carries out one serial flash transaction that software has described in a set of registers. A single pulse on the execute input starts it. The block then walks through up to five phases in a fixed order, skipping any phase whose length is zero. The phases are an opcode byte, an address of up to four bytes, outgoing payload bytes, a dummy phase and incoming payload bytes. Each unit of work goes to an external shifter through a request/acknowledge exchange. The shifter returns one received byte for each exchange.

The register file outside the block supplies a configuration word, a command word, an address word and four outgoing data words. It keeps these stable while the block is busy. Received bytes collect in four incoming data words. When the last phase is finished, the block raises a ready flag and drops its busy flag. Optionally it also drives one of several active-low chip selects around the whole transaction.

Top module: `spi_xact_engine`

## Requirements
- R1: A pulse on `exec_i` while `busy_o` is low makes `busy_o` high at the next clock edge. A pulse while `busy_o` is high is ignored and does not start a second transaction.
- R2: When configuration bit 10 is set, the first exchange sends command bits [7:0] with `xfer_bits_o` = 8.
- R3: Configuration bits [13:11] give an address length of 0 to 4 bytes. The address bytes are sent most significant first, beginning at byte (length-1) of the address word. A value of 5 to 7 sends no address.
- R4: Configuration bits [20:16] give 0 to 31 outgoing bytes. Byte i comes from data-out word i/4, lane i mod 4, where lane 0 is bits [7:0]. Byte i of 16 or more comes from word 3, lane i mod 4.
- R5: Configuration bits [23:21] give 0 to 7 dummy bytes. The chunk width is 1 << cfg[7:6] bits, reported on `xfer_bits_o`. Dummy byte 0 is command bits [15:8] and byte 1 is command bits [23:16]. Every later dummy byte is command bits [31:24]. Each byte is sent as chunks, lowest chunk first, each right-aligned in `xfer_tx_o`.
- R6: Configuration bits [28:24] give 0 to 31 incoming bytes. Each one is an exchange sending 0x00. Received byte i lands in `din_o` bits [8i+7:8i] for i < 16. Bytes with i of 16 or more are exchanged and discarded. Lanes that are not written keep their previous value.
- R7: When `swcs_i` is high at the start, `cs_n_o[devnum_i]` goes low with the start edge and stays low through every exchange. It returns high when the transaction ends. When `swcs_i` is low, all chip selects stay high. No more than one chip select is ever low.
- R8: At completion, `rdy_o` becomes 1 and `busy_o` becomes 0. `rdy_o` stays 1 until a pulse on `rdy_clr_i`.
- R9: The phases run in the order opcode, address, outgoing, dummy, incoming. Zero-length phases are skipped, so a transaction with all lengths zero makes no exchange and still completes.
- R10: `irq_o` is high exactly when `rdy_o` and `rdy_ie_i` are both high.
- R11: After reset, `busy_o`, `rdy_o`, `xfer_req_o` and `din_o` are all 0, and all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Start pulse (execute bit written) |
| cfg_i | input | 32 | Transaction configuration word |
| cmd_i | input | 32 | Opcode byte and dummy-source bytes |
| addr_i | input | 32 | Address word |
| dout_i | input | NW*DW | Outgoing data words, word 0 in the low bits |
| swcs_i | input | 1 | Engine drives chip select for this transaction |
| devnum_i | input | DEVW | Chip select index |
| rdy_ie_i | input | 1 | Ready interrupt enable |
| rdy_clr_i | input | 1 | Clear pulse for the ready flag |
| xfer_ack_i | input | 1 | Shifter finished the current exchange |
| xfer_rx_i | input | 8 | Byte received in the current exchange |
| xfer_req_o | output | 1 | Exchange requested |
| xfer_tx_o | output | 8 | Byte or right-aligned chunk to send |
| xfer_bits_o | output | 4 | Bits in this exchange (1, 2, 4 or 8) |
| din_o | output | NW*DW | Incoming data words |
| busy_o | output | 1 | Transaction in progress (execute bit) |
| rdy_o | output | 1 | Ready status |
| irq_o | output | 1 | Ready interrupt |
| cs_n_o | output | 2**DEVW | Active-low chip selects |

## Verification
The hardest states to reach are the ones where a length field runs past the sixteen bytes of data storage. These are outgoing bytes that wrap back onto the last word, and incoming bytes that are exchanged but must leave storage alone. Close behind are dummy bytes past the second one at each chunk width. The stimulus reaches them by sweeping a small arithmetic grid over every length field, every chunk width, both chip-select modes and every device number. The grid includes counts of 17 to 31 and out-of-range address lengths. A shifter model in the bench logs every exchange so that the complete sequence can be compared with one rebuilt from the requirements.

// File: rtl/spi_xe_pkg.sv
package spi_xe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_WDATA = 3'd3,
    PH_DUMMY = 3'd4,
    PH_RDATA = 3'd5,
    PH_DONE  = 3'd6
  } phase_t;

  // decoded transaction description
  typedef struct packed {
    logic       op_en;
    logic [2:0] alen;
    logic [4:0] wlen;
    logic [2:0] dlen;
    logic [4:0] rlen;
    logic [1:0] bpck;
  } xcfg_t;

  function automatic xcfg_t decode_cfg(logic [31:0] c);
    xcfg_t d;
    d.op_en = c[10];
    d.alen  = c[13:11];
    d.wlen  = c[20:16];
    d.dlen  = c[23:21];
    d.rlen  = c[28:24];
    d.bpck  = c[7:6];
    return d;
  endfunction

  function automatic logic [4:0] phase_len(phase_t ph, xcfg_t d);
    case (ph)
      PH_CMD:   return {4'd0, d.op_en};
      PH_ADDR:  return (d.alen <= 3'd4) ? {2'd0, d.alen} : 5'd0;
      PH_WDATA: return d.wlen;
      PH_DUMMY: return {2'd0, d.dlen};
      PH_RDATA: return d.rlen;
      default:  return 5'd0;
    endcase
  endfunction

  // first non-empty phase after cur, or DONE
  function automatic phase_t next_phase(phase_t cur, xcfg_t d);
    phase_t r;
    r = PH_DONE;
    for (int p = 5; p >= 1; p--) begin
      if (p > int'(cur) && phase_len(phase_t'(3'(p)), d) != 5'd0)
        r = phase_t'(3'(p));
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_xe_seq.sv
module spi_xe_seq
  import spi_xe_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         ack,
  input  xcfg_t        xcfg,
  output phase_t       ph_o,
  output logic [4:0]   cnt_o,
  output logic [2:0]   chunk_o,
  output logic         req_o
);

  phase_t     ph;
  logic [4:0] cnt;
  logic [2:0] chunk;
  logic [4:0] len;
  logic [3:0] per_byte;
  logic [2:0] last_chunk;
  logic       byte_end;

  assign len        = phase_len(ph, xcfg);
  assign per_byte   = 4'd8 >> xcfg.bpck;
  assign last_chunk = 3'(per_byte - 4'd1);
  assign byte_end   = (ph != PH_DUMMY) || (chunk == last_chunk);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      chunk <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          cnt   <= '0;
          chunk <= '0;
          if (start) ph <= next_phase(PH_IDLE, xcfg);
        end
        PH_DONE: ph <= PH_IDLE;
        default: begin
          if (ack) begin
            if (!byte_end) begin
              chunk <= chunk + 3'd1;
            end else begin
              chunk <= '0;
              if (cnt == len - 5'd1) begin
                cnt <= '0;
                ph  <= next_phase(ph, xcfg);
              end else begin
                cnt <= cnt + 5'd1;
              end
            end
          end
        end
      endcase
    end
  end

  assign ph_o    = ph;
  assign cnt_o   = cnt;
  assign chunk_o = chunk;
  assign req_o   = (ph != PH_IDLE) && (ph != PH_DONE);

  AST_CHUNK_OUTSIDE_DUMMY: assert property (@(posedge clk) disable iff (rst)
    (ph != PH_DUMMY) |-> (chunk == 3'd0)); // R5
  AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (cnt < len)); // R9

endmodule

// File: rtl/spi_xe_txmux.sv
module spi_xe_txmux
  import spi_xe_pkg::*;
#(
  parameter int NW = 4,
  parameter int DW = 32
) (
  input  phase_t           ph,
  input  logic [4:0]       cnt,
  input  logic [2:0]       chunk,
  input  logic [2:0]       alen,
  input  logic [1:0]       bpck,
  input  logic [31:0]      cmd,
  input  logic [31:0]      addr,
  input  logic [NW*DW-1:0] dout,
  output logic [7:0]       tx,
  output logic [3:0]       bits
);

  localparam int NB = NW * DW / 8;

  logic [1:0]  abyte;
  logic [7:0]  dsrc;
  logic [3:0]  bpc;
  logic [2:0]  shift;
  logic [7:0]  mask;
  int          widx;

  always_comb begin
    abyte = 2'(alen - 3'd1 - cnt[2:0]);
    widx  = (int'(cnt) < NB) ? int'(cnt) : (NB - 4 + int'(cnt[1:0]));
    bpc   = 4'd1 << bpck;
    shift = 3'(chunk << bpck);
    mask  = 8'((16'd1 << bpc) - 16'd1);
    case (cnt)
      5'd0:    dsrc = cmd[15:8];
      5'd1:    dsrc = cmd[23:16];
      default: dsrc = cmd[31:24];
    endcase
    bits = 4'd8;
    case (ph)
      PH_CMD:   tx = cmd[7:0];
      PH_ADDR:  tx = addr[abyte*8 +: 8];
      PH_WDATA: tx = dout[widx*8 +: 8];
      PH_DUMMY: begin
        tx   = (dsrc >> shift) & mask;
        bits = bpc;
      end
      default:  tx = 8'd0;
    endcase
  end

endmodule

// File: rtl/spi_xe_rxstore.sv
module spi_xe_rxstore #(
  parameter int NW = 4,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [4:0]       idx,
  input  logic [7:0]       rx,
  output logic [NW*DW-1:0] din
);

  localparam int NB = NW * DW / 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      din <= '0;
    end else if (we) begin
      for (int b = 0; b < NB; b++) begin
        if (int'(idx) == b) din[b*8 +: 8] <= rx;
      end
    end
  end

  AST_RX_INDEX_STORED: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(idx) < NB)); // R6

endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
  import spi_xe_pkg::*;
#(
  parameter int NW   = 4,
  parameter int DW   = 32,
  parameter int DEVW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 exec_i,
  input  logic [31:0]          cfg_i,
  input  logic [31:0]          cmd_i,
  input  logic [31:0]          addr_i,
  input  logic [NW*DW-1:0]     dout_i,
  input  logic                 swcs_i,
  input  logic [DEVW-1:0]      devnum_i,
  input  logic                 rdy_ie_i,
  input  logic                 rdy_clr_i,
  input  logic                 xfer_ack_i,
  input  logic [7:0]           xfer_rx_i,
  output logic                 xfer_req_o,
  output logic [7:0]           xfer_tx_o,
  output logic [3:0]           xfer_bits_o,
  output logic [NW*DW-1:0]     din_o,
  output logic                 busy_o,
  output logic                 rdy_o,
  output logic                 irq_o,
  output logic [(1<<DEVW)-1:0] cs_n_o
);

  localparam int NCS = 1 << DEVW;
  localparam int NB  = NW * DW / 8;

  xcfg_t      xcfg;
  phase_t     ph;
  logic [4:0] cnt;
  logic [2:0] chunk;
  logic       start;
  logic       rx_we;
  logic       busy_q, rdy_q, swcs_q;
  logic [NCS-1:0] cs_n_q;
  logic       unused_cfg;

  assign xcfg       = decode_cfg(cfg_i);
  assign unused_cfg = ^{cfg_i[31:29], cfg_i[9:8], cfg_i[5:0]};
  assign start      = exec_i && !busy_q;
  assign rx_we      = xfer_ack_i && (ph == PH_RDATA) && (int'(cnt) < NB);

  spi_xe_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ack     (xfer_ack_i),
    .xcfg    (xcfg),
    .ph_o    (ph),
    .cnt_o   (cnt),
    .chunk_o (chunk),
    .req_o   (xfer_req_o)
  );

  spi_xe_txmux #(.NW(NW), .DW(DW)) u_txmux (
    .ph    (ph),
    .cnt   (cnt),
    .chunk (chunk),
    .alen  (xcfg.alen),
    .bpck  (xcfg.bpck),
    .cmd   (cmd_i),
    .addr  (addr_i),
    .dout  (dout_i),
    .tx    (xfer_tx_o),
    .bits  (xfer_bits_o)
  );

  spi_xe_rxstore #(.NW(NW), .DW(DW)) u_rxstore (
    .clk (clk),
    .rst (rst),
    .we  (rx_we),
    .idx (cnt),
    .rx  (xfer_rx_i),
    .din (din_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      swcs_q <= 1'b0;
      cs_n_q <= '1;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        swcs_q <= swcs_i;
        if (swcs_i) cs_n_q <= ~(NCS'(1) << devnum_i);
      end else if (ph == PH_DONE) begin
        busy_q <= 1'b0;
        if (swcs_q) cs_n_q <= '1;
      end
      if (ph == PH_DONE)  rdy_q <= 1'b1;
      else if (rdy_clr_i) rdy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign rdy_o  = rdy_q;
  assign irq_o  = rdy_q && rdy_ie_i;
  assign cs_n_o = cs_n_q;

  AST_BUSY_ONLY_FROM_EXEC: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(exec_i)); // R1
  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_q)); // R7
  AST_CS_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (&cs_n_q)); // R7
  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DONE) |=> (rdy_q && !busy_q)); // R8
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    xfer_req_o |-> busy_q); // R9
  AST_CHUNK_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
    xfer_req_o |-> ($countones(xfer_bits_o) == 1)); // R5

endmodule

// File: tb/spi_xact_engine_tb_top.sv
`timescale 1ns/1ps
module spi_xact_engine_tb_top;

  localparam int NW = 4, DW = 32, DEVW = 2, NCS = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic exec = 1'b0, swcs = 1'b0, ie = 1'b0, clr = 1'b0, log_clr = 1'b0;
  logic [31:0] cfg = '0, cmd = '0, addr = '0;
  logic [NW*DW-1:0] dout;
  logic [DEVW-1:0] dev = '0;
  logic ack, req, busy, rdy, irq;
  logic [7:0] rx, tx;
  logic [3:0] bits;
  logic [NW*DW-1:0] din;
  logic [NCS-1:0] cs_n;

  int checks = 0, errors = 0;
  int xidx;
  logic [7:0] log_tx [256];
  logic [3:0] log_bits [256];
  logic [NCS-1:0] log_cs [256];
  logic [7:0] e_tx [256];
  logic [3:0] e_bits [256];
  int e_tag [256];
  int n_exp;
  logic [NW*DW-1:0] e_din;

  always #4 clk = ~clk;

  spi_xact_engine #(.NW(NW), .DW(DW), .DEVW(DEVW)) dut_i (
    .clk(clk), .rst(rst), .exec_i(exec), .cfg_i(cfg), .cmd_i(cmd),
    .addr_i(addr), .dout_i(dout), .swcs_i(swcs), .devnum_i(dev),
    .rdy_ie_i(ie), .rdy_clr_i(clr), .xfer_ack_i(ack), .xfer_rx_i(rx),
    .xfer_req_o(req), .xfer_tx_o(tx), .xfer_bits_o(bits), .din_o(din),
    .busy_o(busy), .rdy_o(rdy), .irq_o(irq), .cs_n_o(cs_n)
  );

  // shifter model: one-cycle acknowledge, logs every exchange
  always @(posedge clk) begin
    if (rst || log_clr) begin
      ack  <= 1'b0;
      rx   <= 8'h00;
      xidx <= 0;
    end else if (req && !ack) begin
      ack  <= 1'b1;
      rx   <= 8'h5A ^ 8'(xidx);
      if (xidx < 256) begin
        log_tx[xidx]   <= tx;
        log_bits[xidx] <= bits;
        log_cs[xidx]   <= cs_n;
      end
      xidx <= xidx + 1;
    end else begin
      ack <= 1'b0;
    end
  end

  function automatic string tag_name(int t);
    case (t)
      2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req_s, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_s, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v, input logic [3:0] b, input int tg);
    e_tx[n_exp] = v; e_bits[n_exp] = b; e_tag[n_exp] = tg; n_exp++;
  endtask

  task automatic run_case(input bit csz, input int asz, input int wc, input int dsz,
                          input int bpck, input int rc, input bit sc, input int dv,
                          input bit ien, input bit poke, input int t);
    int na, bpc, rbase, waited;
    logic [7:0] db;
    logic [NCS-1:0] ecs;
    cfg  = (32'(rc) << 24) | (32'(dsz) << 21) | (32'(wc) << 16) |
           (32'(asz) << 11) | (32'(csz) << 10) | (32'(bpck) << 6);
    cmd  = {8'hC3 ^ 8'(t), 8'h96 + 8'(t), 8'h2D ^ 8'(t*3), 8'h9F ^ 8'(t)};
    addr = 32'h11223344 + 32'(t) * 32'h01010101;
    swcs = sc; dev = DEVW'(dv); ie = ien;
    // expected exchange sequence
    n_exp = 0;
    if (csz) push(cmd[7:0], 4'd8, 2);
    na = (asz <= 4) ? asz : 0;
    for (int k = na - 1; k >= 0; k--) push(addr[k*8 +: 8], 4'd8, 3);
    for (int i = 0; i < wc; i++) push(8'h30 + 8'((i < 16) ? i : 12 + i % 4), 4'd8, 4);
    bpc = 1 << bpck;
    for (int d = 0; d < dsz; d++) begin
      db = (d == 0) ? cmd[15:8] : (d == 1) ? cmd[23:16] : cmd[31:24];
      for (int c = 0; c < 8; c += bpc) push(8'((db >> c) & ((1 << bpc) - 1)), 4'(bpc), 5);
    end
    rbase = n_exp;
    for (int i = 0; i < rc; i++) begin
      push(8'h00, 4'd8, 6);
      if (i < 16) e_din[i*8 +: 8] = 8'h5A ^ 8'(rbase + i);
    end
    ecs = sc ? ~(NCS'(1) << dv) : '1;
    // launch
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0; exec = 1'b1;
    @(negedge clk); exec = 1'b0;
    chk(busy === 1'b1, "R1", "busy after start", 128'(busy), 128'(1));
    if (poke) begin
      exec = 1'b1;            // R1: ignored while busy
      @(negedge clk); exec = 1'b0;
    end
    waited = 0;
    while (busy === 1'b1 && waited < 3000) begin @(negedge clk); waited++; end
    repeat (2) @(negedge clk);
    chk(xidx == n_exp, "R9", "exchange count", 128'(xidx), 128'(n_exp));
    for (int i = 0; i < n_exp && i < xidx; i++) begin
      chk(log_tx[i] === e_tx[i] && log_bits[i] === e_bits[i], tag_name(e_tag[i]),
          $sformatf("exchange %0d data/bits", i), {log_tx[i], log_bits[i]}, {e_tx[i], e_bits[i]});
      chk(log_cs[i] === ecs, "R7", $sformatf("chip select at exchange %0d", i),
          128'(log_cs[i]), 128'(ecs));
    end
    chk(din === e_din, "R6", "incoming words", din, e_din);
    chk(rdy === 1'b1 && busy === 1'b0, "R8", "ready/busy at end", {rdy, busy}, 2'b10);
    chk(irq === ien, "R10", "irq with ready", 128'(irq), 128'(ien));
    chk(cs_n === '1, "R7", "chip selects after end", 128'(cs_n), 128'(4'hF));
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(rdy === 1'b0 && irq === 1'b0, "R8", "ready cleared", {rdy, irq}, 2'b00);
  endtask

  initial begin
    for (int j = 0; j < NW * DW / 8; j++) dout[j*8 +: 8] = 8'h30 + 8'(j);
    e_din = '0;
    ie = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && rdy === 1'b0 && req === 1'b0 && irq === 1'b0, "R11",
        "reset flags", {busy, rdy, req, irq}, 4'b0000);
    chk(cs_n === '1, "R11", "reset chip selects", 128'(cs_n), 128'(4'hF));
    chk(din === '0, "R11", "reset incoming words", din, '0);
    // R9: all lengths zero, no exchange
    run_case(1'b0, 0, 0, 0, 0, 0, 1'b1, 2, 1'b1, 1'b1, 99);
    // grid sweep over all fields (R2..R7)
    for (int t = 0; t < 48; t++) begin
      run_case(1'(t % 2), (t / 2) % 8, (t * 7) % 32, (t * 3) % 8, (t / 3) % 4,
               (t * 5 + 3) % 32, (t % 3) != 0, (t / 4) % 4, 1'((t / 5) % 2),
               (t % 5) == 0, t);
    end
    // R4/R6 extremes: 31 outgoing, 31 incoming, 8-bit chunks
    run_case(1'b1, 4, 31, 7, 3, 31, 1'b1, 3, 1'b1, 1'b0, 200);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule